// File: doc/BRIEF.md
# Stereo Serial Audio Word Transmitter

This block takes one left and one right audio sample per frame and shifts both out, most significant bit first, on a single serial data line. A frame lasts 64 bit-clock periods and is split into two 32-slot halves: the left word goes out in the first half, the right word in the second. Both words are captured together at the frame boundary, so the pair always comes from the same sampling instant. A one-cycle `pair_taken` pulse tells the sample source that new words may be presented.

Four static mode inputs give sixteen formats. They select master or slave clocking, the position of the frame-sync rising edge (one bit ahead of the data, or on the first bit), where the word sits inside its half (at the start or at the end), and what the line does in the sixteen unused slots of each half (released or driven low). In master mode the block makes the bit clock (two internal clocks per bit) and the frame sync. In slave mode both arrive as inputs. They pass through a resynchronizer on the internal clock, and the data advances on each detected rising bit-clock edge. Mode inputs take effect only at reset and at frame boundaries.

Top module: `stereo_ser_tx`

## Requirements
- R1: In master mode `bclk_out` inverts on every internal clock, giving a 64-bit frame of 128 clocks, and `bclk_oe` and `fsync_oe` are 1. In slave mode (`cfg_slave`=1) both enables are 0.
- R2: Data changes only when the bit clock rises. Slot 0 carries left bit 15 first, bits leave MSB first, and the left word precedes the right word (slots 0-31 left, 32-63 right).
- R3: `fsync_out` is high for 32 slots and low for 32 slots. With `cfg_sync_coincide`=1 it is high in slots 0 to 31. With `cfg_sync_coincide`=0 it rises in slot 63, one bit before slot 0, and is high in slots 63 and 0 to 30.
- R4: With `cfg_right_just`=0 a word occupies slot offsets 0 to 15 of its half. With `cfg_right_just`=1 it occupies offsets 16 to 31, so its LSB lands in the last slot of the half.
- R5: In the 16 unused slots of a half, `sdo_oe`=0 when `cfg_idle_low`=0. When `cfg_idle_low`=1, `sdo_oe`=1 and `sdo`=0.
- R6: `left_word` and `right_word` are both captured at the frame boundary. `pair_taken` is high for the one clock that follows the capture, and changes to the word inputs at other times do not alter the frame being sent.
- R7: The four mode inputs are latched at reset and at each frame boundary only. A change made during a frame applies from the next frame.
- R8: In slave mode `bclk_in` and `fsync_in` pass through a two-flop resynchronizer. Each detected rising bit-clock edge advances one slot. A rising `fsync_in` seen at a bit-clock rise aligns the slot count to slot 0 (`cfg_sync_coincide`=1) or slot 63 (`cfg_sync_coincide`=0). Before the first such sync edge no frame starts.
- R9: From reset until the first frame starts, `sdo_oe`, `sdo`, `fsync_out` and `pair_taken` stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal sample clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_slave | input | 1 | 1: bit clock and sync are inputs |
| cfg_sync_coincide | input | 1 | 1: sync rises on the first data bit; 0: one bit earlier |
| cfg_right_just | input | 1 | 1: word ends at the close of its half-frame |
| cfg_idle_low | input | 1 | 1: drive low in unused slots; 0: release the line |
| left_word | input | WORD_W | Left sample |
| right_word | input | WORD_W | Right sample |
| pair_taken | output | 1 | One-clock pulse after both words are captured |
| sdo | output | 1 | Serial data value |
| sdo_oe | output | 1 | Serial data output enable |
| bclk_in | input | 1 | External bit clock (slave) |
| bclk_out | output | 1 | Generated bit clock (master) |
| bclk_oe | output | 1 | Bit-clock direction: 1 drives |
| fsync_in | input | 1 | External frame sync (slave) |
| fsync_out | output | 1 | Generated frame sync (master) |
| fsync_oe | output | 1 | Sync direction: 1 drives |

## Verification
The assertions take for granted that the mode inputs and the word inputs change only away from a frame boundary. They also assume that in slave mode each level of `bclk_in` lasts at least two internal clocks and that `fsync_in` changes only together with a rising bit-clock edge. The stimulus meets these conditions. It changes the modes and the words only in the clock after `pair_taken`, in the middle of a frame, and it drives the slave bit clock at eight internal clocks per bit, with sync changing on the rise. Mode switches between master and slave happen only under reset.

// File: rtl/ser_tx_pkg.sv
package ser_tx_pkg;
   typedef struct packed {
      logic slave;
      logic sync_coincide;
      logic right_just;
      logic idle_low;
   } txmode_t;
endpackage

// File: rtl/ser_tx_resync.sv
module ser_tx_resync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   always_ff @(posedge clk) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/ser_tx_timing.sv
module ser_tx_timing #(
   parameter int FRAME_W = 64,
   localparam int SLOT_BITS = $clog2(FRAME_W)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 slave,
   input  logic                 coincide,
   input  logic                 bclk_s,
   input  logic                 sync_s,
   output logic [SLOT_BITS-1:0] slot,
   output logic                 adv,
   output logic                 frame_start,
   output logic                 run,
   output logic                 hb
);
   localparam logic [SLOT_BITS-1:0] LAST = SLOT_BITS'(FRAME_W - 1);
   localparam logic [SLOT_BITS-1:0] ONE  = SLOT_BITS'(1);

   logic [SLOT_BITS-1:0] slot_q, slot_nxt;
   logic hb_q, locked_q, bs_d, sp_q, run_q;
   logic bclk_rise, sync_rise;

   assign bclk_rise = bclk_s & ~bs_d;
   assign sync_rise = sync_s & ~sp_q;

   always_comb begin
      if (!slave) begin
         adv      = ~hb_q;
         slot_nxt = slot_q + ONE;
      end else begin
         adv      = bclk_rise & (locked_q | sync_rise);
         if (sync_rise) slot_nxt = coincide ? '0 : LAST;
         else           slot_nxt = slot_q + ONE;
      end
   end

   assign frame_start = adv & (slot_nxt == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hb_q     <= 1'b1;
         slot_q   <= LAST;
         locked_q <= 1'b0;
         bs_d     <= 1'b0;
         sp_q     <= 1'b0;
         run_q    <= 1'b0;
      end else begin
         bs_d <= bclk_s;
         hb_q <= slave ? 1'b1 : ~hb_q;
         if (bclk_rise) sp_q <= sync_s;
         if (slave && bclk_rise && sync_rise) locked_q <= 1'b1;
         if (adv) slot_q <= slot_nxt;
         if (frame_start) run_q <= 1'b1;
      end
   end

   assign slot = slot_q;
   assign run  = run_q;
   assign hb   = hb_q;
endmodule

// File: rtl/ser_tx_slotmux.sv
module ser_tx_slotmux #(
   parameter int WORD_W = 16,
   parameter int HALF_W = 32,
   localparam int SLOT_BITS = $clog2(2 * HALF_W),
   localparam int IDX_W = $clog2(WORD_W)
) (
   input  logic [SLOT_BITS-1:0] slot,
   input  logic [WORD_W-1:0]    left_q,
   input  logic [WORD_W-1:0]    right_q,
   input  ser_tx_pkg::txmode_t  mode,
   input  logic                 run,
   output logic                 sdo,
   output logic                 sdo_oe,
   output logic                 sync_lvl
);
   localparam int PW = SLOT_BITS - 1;
   localparam logic [PW-1:0] RJ_FIRST  = PW'(HALF_W - WORD_W);
   localparam logic [PW-1:0] LJ_END    = PW'(WORD_W);
   localparam logic [PW-1:0] HALF_LAST = PW'(HALF_W - 1);
   localparam logic [PW-1:0] WORD_LAST = PW'(WORD_W - 1);

   logic          in_right;
   logic [PW-1:0] pos, raw;
   logic          valid;
   logic [WORD_W-1:0]    word;
   logic [SLOT_BITS-1:0] shifted;

   assign in_right = slot[SLOT_BITS-1];
   assign pos      = slot[PW-1:0];
   assign word     = in_right ? right_q : left_q;

   always_comb begin
      if (mode.right_just) begin
         valid = (pos >= RJ_FIRST);
         raw   = HALF_LAST - pos;
      end else begin
         valid = (pos < LJ_END);
         raw   = WORD_LAST - pos;
      end
   end

   assign sdo     = run & valid & word[raw[IDX_W-1:0]];
   assign sdo_oe  = run & (valid | mode.idle_low);
   assign shifted = slot + {{(SLOT_BITS-1){1'b0}}, ~mode.sync_coincide};
   assign sync_lvl = run & ~shifted[SLOT_BITS-1];
endmodule

// File: rtl/stereo_ser_tx.sv
module stereo_ser_tx #(
   parameter int WORD_W      = 16,
   parameter int HALF_W      = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_slave,
   input  logic              cfg_sync_coincide,
   input  logic              cfg_right_just,
   input  logic              cfg_idle_low,
   input  logic [WORD_W-1:0] left_word,
   input  logic [WORD_W-1:0] right_word,
   output logic              pair_taken,
   output logic              sdo,
   output logic              sdo_oe,
   input  logic              bclk_in,
   output logic              bclk_out,
   output logic              bclk_oe,
   input  logic              fsync_in,
   output logic              fsync_out,
   output logic              fsync_oe
);
   import ser_tx_pkg::*;

   localparam int FRAME_W   = 2 * HALF_W;
   localparam int SLOT_BITS = $clog2(FRAME_W);

   if ((HALF_W & (HALF_W - 1)) != 0) begin : g_half_pow2
      $error("HALF_W must be a power of two");
   end
   if (WORD_W < 2 || WORD_W > HALF_W) begin : g_word_fit
      $error("WORD_W must lie in 2..HALF_W");
   end
   if (SYNC_STAGES < 2) begin : g_stages
      $error("SYNC_STAGES must be at least 2");
   end

   txmode_t mode_q, mode_in;
   logic [WORD_W-1:0] left_q, right_q;
   logic [1:0] raw_in, synced;
   logic [SLOT_BITS-1:0] slot;
   logic adv, frame_start, run, hb, sync_lvl;

   assign mode_in = '{slave: cfg_slave, sync_coincide: cfg_sync_coincide,
                      right_just: cfg_right_just, idle_low: cfg_idle_low};
   assign raw_in  = {fsync_in, bclk_in};

   for (genvar i = 0; i < 2; i++) begin : g_rs
      ser_tx_resync #(.STAGES(SYNC_STAGES)) u_rs (
         .clk(clk), .rst_n(rst_n), .d(raw_in[i]), .q(synced[i]));
   end

   ser_tx_timing #(.FRAME_W(FRAME_W)) u_tim (
      .clk(clk), .rst_n(rst_n), .slave(mode_q.slave),
      .coincide(mode_q.sync_coincide), .bclk_s(synced[0]), .sync_s(synced[1]),
      .slot(slot), .adv(adv), .frame_start(frame_start), .run(run), .hb(hb));

   ser_tx_slotmux #(.WORD_W(WORD_W), .HALF_W(HALF_W)) u_mux (
      .slot(slot), .left_q(left_q), .right_q(right_q), .mode(mode_q),
      .run(run), .sdo(sdo), .sdo_oe(sdo_oe), .sync_lvl(sync_lvl));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q     <= mode_in;
         left_q     <= '0;
         right_q    <= '0;
         pair_taken <= 1'b0;
      end else begin
         pair_taken <= frame_start;
         if (frame_start) begin
            mode_q  <= mode_in;
            left_q  <= left_word;
            right_q <= right_word;
         end
      end
   end

   assign bclk_out  = ~mode_q.slave & hb;
   assign bclk_oe   = ~mode_q.slave;
   assign fsync_out = ~mode_q.slave & sync_lvl;
   assign fsync_oe  = ~mode_q.slave;

   // R2: line holds between slot advances
   p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !adv |=> ($stable(sdo) && $stable(sdo_oe)));
   // R9: nothing driven before the first frame
   p_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !run |-> (!sdo_oe && !sdo && !fsync_out));
   // R1: master bit clock inverts every clock
   p_bclk_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_q.slave && !frame_start) |=> (bclk_out != $past(bclk_out)));
   // R3: leading sync edge two clocks before the frame boundary pulse
   p_sync_lead_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(fsync_out) && !pair_taken && !mode_q.slave && !mode_q.sync_coincide)
      |-> ##2 pair_taken);
   // R3: coincident sync edge lines up with the boundary pulse
   p_sync_coinc_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(fsync_out) && !mode_q.slave && mode_q.sync_coincide) |-> pair_taken);
   // R6: capture pulse only while slot 0 is on the line
   p_pair_slot0_r6: assert property (@(posedge clk) disable iff (!rst_n)
      pair_taken |-> (slot == '0));
endmodule

// File: tb/stereo_ser_tx_test.sv
`timescale 1ns/1ps
module stereo_ser_tx_test;
   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic rst_n, cfg_slave, cfg_sync_coincide, cfg_right_just, cfg_idle_low;
   logic [15:0] left_word, right_word;
   logic pair_taken, sdo, sdo_oe, bclk_in, bclk_out, bclk_oe;
   logic fsync_in, fsync_out, fsync_oe;

   stereo_ser_tx uut (
      .clk(clk), .rst_n(rst_n), .cfg_slave(cfg_slave),
      .cfg_sync_coincide(cfg_sync_coincide), .cfg_right_just(cfg_right_just),
      .cfg_idle_low(cfg_idle_low), .left_word(left_word), .right_word(right_word),
      .pair_taken(pair_taken), .sdo(sdo), .sdo_oe(sdo_oe), .bclk_in(bclk_in),
      .bclk_out(bclk_out), .bclk_oe(bclk_oe), .fsync_in(fsync_in),
      .fsync_out(fsync_out), .fsync_oe(fsync_oe));

   typedef struct packed { logic sdo; logic oe; logic sync; logic idle; } item_t;
   item_t q[$];

   int errors = 0, checks = 0, frames_seen = 0, ecnt = 0, k = 61;
   bit started = 0, slave_phase = 0, ext_mode = 0, done = 0;
   logic prev_bclk = 1'b0;

   task automatic check(bit ok, string tag, string what, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   // driver side: expected slots of one frame
   task automatic push_frame(logic [15:0] l, logic [15:0] r, logic coinc,
                             logic rj, logic il);
      for (int s = 0; s < 64; s++) begin
         item_t it;
         int pos = s % 32;
         logic [15:0] w = (s >= 32) ? r : l;
         bit valid = rj ? (pos >= 16) : (pos < 16);
         int idx = rj ? 31 - pos : 15 - pos;
         it.sdo  = valid ? w[idx] : 1'b0;
         it.oe   = valid | il;
         it.sync = (((s + (coinc ? 0 : 1)) % 64) < 32);
         it.idle = !valid;
         q.push_back(it);
      end
   endtask

   // monitor side
   task automatic compare(bit slv);
      item_t it;
      string tag;
      if (q.size() == 0) begin
         check(0, "R2", "queue empty", 0, 1);
         return;
      end
      it = q.pop_front();
      if (slv) tag = "R8";
      else if (it.idle) tag = "R5";
      else tag = "R2 R4 R6 R7";
      check(sdo_oe == it.oe, tag, "sdo_oe", int'(sdo_oe), int'(it.oe));
      check(sdo == it.sdo, tag, "sdo", int'(sdo), int'(it.sdo));
      if (!slv) check(fsync_out == it.sync, "R3", "fsync_out", int'(fsync_out), int'(it.sync));
      else check(!bclk_oe && !fsync_oe, "R1", "slave enables", int'({bclk_oe, fsync_oe}), 0);
   endtask

   function automatic logic [15:0] lw(int f);
      return 16'hC35A ^ (16'(f) * 16'h2F1B);
   endfunction

   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (pair_taken) begin
            push_frame(left_word, right_word, cfg_sync_coincide, cfg_right_just, cfg_idle_low);
            frames_seen++;
            started = 1;
            left_word  = lw(frames_seen);
            right_word = {lw(frames_seen)[7:0], lw(frames_seen)[15:8]} ^ 16'h0F0F;
            if (!slave_phase) begin
               case (frames_seen)
                  2: begin cfg_right_just = 1; cfg_idle_low = 1; end
                  3: begin cfg_sync_coincide = 0; cfg_right_just = 0; end
                  4: begin cfg_right_just = 1; cfg_idle_low = 0; end
                  5: begin cfg_sync_coincide = 1; cfg_right_just = 0; cfg_idle_low = 1; end
                  default: ;
               endcase
            end
         end
         if (!slave_phase) begin
            if (started) begin
               check(bclk_out != prev_bclk, "R1", "bclk toggle", int'(bclk_out), int'(!prev_bclk));
               if (bclk_out && !prev_bclk) compare(0);
            end
            prev_bclk = bclk_out;
         end else begin
            if (!ext_mode) begin
               check(!pair_taken && !sdo_oe, "R8", "pre-lock quiet", int'({pair_taken, sdo_oe}), 0);
            end else if (ecnt == 0 && started) begin
               compare(1);
            end
            if (ecnt == 0) begin
               bclk_in = 1'b1;
               if (ext_mode) begin
                  k = (k + 1) % 64;
                  fsync_in = (((k + (cfg_sync_coincide ? 0 : 1)) % 64) < 32);
               end else fsync_in = 1'b0;
            end else if (ecnt == 4) bclk_in = 1'b0;
            ecnt = (ecnt + 1) % 8;
         end
      end
   end

   task automatic slave_run(logic coinc, logic rj, logic il);
      rst_n = 1'b0;
      cfg_slave = 1; cfg_sync_coincide = coinc; cfg_right_just = rj; cfg_idle_low = il;
      q.delete(); started = 0; frames_seen = 0; slave_phase = 1; ext_mode = 0;
      ecnt = 0; k = 61; bclk_in = 0; fsync_in = 0;
      repeat (3) @(posedge clk);
      #1;
      check(!bclk_oe && !fsync_oe, "R1", "slave dir at reset", int'({bclk_oe, fsync_oe}), 0);
      check(!sdo_oe && !pair_taken, "R9", "slave reset quiet", int'({sdo_oe, pair_taken}), 0);
      rst_n = 1'b1;
      repeat (48) @(posedge clk);
      #1;
      ext_mode = 1;
      wait (frames_seen >= 4);
      repeat (520) @(posedge clk);
      #1;
   endtask

   task automatic finish_run();
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      rst_n = 0; cfg_slave = 0; cfg_sync_coincide = 1; cfg_right_just = 0; cfg_idle_low = 0;
      left_word = 16'h8001; right_word = 16'h7FFE; bclk_in = 0; fsync_in = 0;
      repeat (3) @(posedge clk);
      #1;
      check(!sdo_oe && !sdo && !fsync_out && !pair_taken, "R9", "reset outputs",
            int'({sdo_oe, sdo, fsync_out, pair_taken}), 0);
      check(bclk_oe && fsync_oe, "R1", "master dir", int'({bclk_oe, fsync_oe}), 3);
      rst_n = 1;
      @(posedge clk);
      #1;
      check(!sdo_oe && !fsync_out, "R9", "before first frame", int'({sdo_oe, fsync_out}), 0);
      wait (frames_seen >= 7);
      repeat (140) @(posedge clk);
      #1;
      slave_run(1'b0, 1'b1, 1'b1);
      slave_run(1'b1, 1'b0, 1'b0);
      finish_run();
   end

   initial begin
      repeat (60000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired R2 actual=0 expected=1");
         finish_run();
      end
   end
endmodule